// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Holding Buffer and Break Detection

This block turns a serial asynchronous line into parallel characters. A sample-clock enable (`smp_en`) pulses at 1, 16 or 64 times the bit rate, as chosen by `rate_sel`. The line is first brought into the `clk` domain through a short synchronizer chain. The frame state machine then waits for a high-to-low change on the line. In the 16x and 64x modes it checks the line again half a bit later and drops the event as noise if the line is high by then. Once a start is accepted, the machine samples every later bit one full bit period after the previous sample. Data arrives least significant bit first into a shift register. An optional parity bit follows, and then one or two stop bits.

After the last stop bit the finished character is copied into a separate holding register. `rx_rdy` is raised, and the shift register is free for the next frame. The host takes the character and pulses `rd_ack`. The parity, framing and overrun flags always describe the character now in the holding register. A separate counter watches for a line held low longer than two whole frames and reports this as a break.

State machine: `ST_IDLE` (wait for a falling edge) goes on edge to `ST_START` (16x/64x), or straight to `ST_DATA` (1x). `ST_START` goes on half-bit confirmation to `ST_DATA`, or back to `ST_IDLE` when the line is high again. `ST_DATA` goes after the last data bit to `ST_PAR` when parity is on, else to `ST_STOP1`. `ST_PAR` goes to `ST_STOP1`. `ST_STOP1` goes to `ST_STOP2` when two stop bits are selected, else to `ST_LOAD`. `ST_STOP2` goes to `ST_LOAD`. `ST_LOAD` transfers the character and returns to `ST_IDLE`. Whenever `rx_en` is low, every state goes to `ST_IDLE`.

Top module: `async_rx_dbuf`

## Requirements
- R1: After reset `rx_rdy`, `rx_data`, `err_overrun`, `err_frame`, `err_parity` and `brk_det` are all 0.
- R2: In the 16x and 64x modes a falling edge is confirmed by a sample half a bit time later. If the line is high at that sample, nothing is loaded and the block waits for a new falling edge.
- R3: Data bits are sampled one bit time apart, at the bit centres, and assembled least significant bit first. `char_len` selects 5 + `char_len` data bits (00 = 5 through 11 = 8). The character is right-justified in `rx_data` with unused upper bits 0.
- R4: `rate_sel` sets the number of `smp_en` pulses per bit: 00 gives 1, 01 gives 16, and 10 or 11 give 64.
- R5: With `par_en` = 1 a parity bit follows the data. With `par_odd` = 0 the data bits plus the parity bit must hold an even number of ones; with `par_odd` = 1, an odd number. On a mismatch `err_parity` is 1 for that character, otherwise 0.
- R6: `stop_two` = 1 expects two stop bits and 0 expects one. If any stop bit is sampled as 0, `err_frame` is 1 for that character.
- R7: A completed character is copied to `rx_data` and sets `rx_rdy`. `rx_data` does not change while the next frame is still arriving.
- R8: A one-cycle `rd_ack` pulse clears `rx_rdy` on the next clock and leaves `rx_data` unchanged.
- R9: A character that completes while `rx_rdy` is still 1 replaces `rx_data` and sets `err_overrun` to 1. A character that completes while `rx_rdy` is 0 sets `err_overrun` to 0.
- R10: `brk_det` rises once the line has been sampled low on 2 x (1 + data bits + parity bit + stop bits) x rate consecutive `smp_en` pulses, and falls at the first pulse that samples the line high.
- R11: While `rx_en` is 0 the line is ignored: no frame is received, `rx_rdy` is not set, `rx_data` keeps its value and `brk_det` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Sample-clock enable at 1, 16 or 64 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial input line, idle high |
| rate_sel | input | 2 | Sample pulses per bit: 00 = 1, 01 = 16, 1x = 64 |
| char_len | input | 2 | Data bits per character minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_two | input | 1 | 1 = two stop bits, 0 = one |
| rd_ack | input | 1 | Host has taken the held character |
| rx_data | output | 8 | Held character, right-justified |
| rx_rdy | output | 1 | Holding register contains an unread character |
| err_overrun | output | 1 | Held character replaced an unread one |
| err_frame | output | 1 | A stop bit of the held character was 0 |
| err_parity | output | 1 | Parity of the held character was wrong |
| brk_det | output | 1 | Line held low for more than two frame times |

## Verification
A bit counter or sample counter that is off by one shifts every sample point. This shows up at the ports as a character shifted by one position, or as a false framing flag, on the first frame received in that mode. A start check that does not go back to idle appears as a character that was never sent, within one frame time after a short glitch. A broken holding-register handshake shows up within a cycle or two of `rd_ack` or of the next completed frame, as a stale `rx_rdy` or a wrong overrun flag. The break counter threshold is only visible after two frame times of low line, so it is tested on both sides of the limit.

// File: rtl/rxa_pkg.sv
`timescale 1ns/1ps
package rxa_pkg;

    // Frame reception phases, in the order a character passes through them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_LOAD
    } rx_state_e;

endpackage

// File: rtl/rxa_line_sync.sv
`timescale 1ns/1ps
module rxa_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic line
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= rxd;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign line = chain_q[STAGES-1];

endmodule

// File: rtl/rxa_frame_fsm.sv
`timescale 1ns/1ps
module rxa_frame_fsm
    import rxa_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int CNT_W  = 6,
    localparam int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              rx_en,
    input  logic              is_x1,
    input  logic [CNT_W-1:0]  full_m1,
    input  logic [CNT_W-1:0]  half_m1,
    input  logic [LEN_W-1:0]  nbits_m1,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop_two,
    output logic              load,
    output logic [DATA_W-1:0] char_o,
    output logic              frame_err,
    output logic              par_err
);

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [LEN_W-1:0]   idx_q;
    logic [DATA_W-1:0]  shreg_q;
    logic               prev_q;
    logic               xor_q;
    logic               pbit_q;
    logic               ferr_q;
    logic               cnt_zero;
    logic               last_bit;
    logic [CNT_W-1:0]   cnt_next;
    logic [LEN_W:0]     shamt;

    assign cnt_zero = (cnt_q == '0);
    assign last_bit = (idx_q == nbits_m1);
    assign cnt_next = cnt_zero ? full_m1 : cnt_q - CNT_W'(1);
    assign shamt    = (LEN_W+1)'(DATA_W - 1) - {1'b0, nbits_m1};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!rx_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (tick && prev_q && !line)
                              state_d = is_x1 ? ST_DATA : ST_START;
                ST_START: if (tick && cnt_zero)
                              state_d = line ? ST_IDLE : ST_DATA;
                ST_DATA:  if (tick && cnt_zero && last_bit)
                              state_d = par_en ? ST_PAR : ST_STOP1;
                ST_PAR:   if (tick && cnt_zero)
                              state_d = ST_STOP1;
                ST_STOP1: if (tick && cnt_zero)
                              state_d = stop_two ? ST_STOP2 : ST_LOAD;
                ST_STOP2: if (tick && cnt_zero)
                              state_d = ST_LOAD;
                ST_LOAD:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Bit timing and character assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            prev_q  <= 1'b1;
            xor_q   <= 1'b0;
            pbit_q  <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            if (tick) prev_q <= line;
            if (!rx_en) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else if (tick) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (prev_q && !line) begin
                            cnt_q   <= is_x1 ? full_m1 : half_m1;
                            idx_q   <= '0;
                            shreg_q <= '0;
                            xor_q   <= 1'b0;
                            pbit_q  <= 1'b0;
                            ferr_q  <= 1'b0;
                        end
                    end
                    ST_START: cnt_q <= cnt_next;
                    ST_DATA: begin
                        cnt_q <= cnt_next;
                        if (cnt_zero) begin
                            shreg_q <= {line, shreg_q[DATA_W-1:1]};
                            xor_q   <= xor_q ^ line;
                            idx_q   <= idx_q + LEN_W'(1);
                        end
                    end
                    ST_PAR: begin
                        cnt_q <= cnt_next;
                        if (cnt_zero) pbit_q <= line;
                    end
                    ST_STOP1, ST_STOP2: begin
                        cnt_q <= cnt_next;
                        if (cnt_zero && !line) ferr_q <= 1'b1;
                    end
                    ST_LOAD: cnt_q <= '0;
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    // Outputs: transfer pulse and finished character
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load      <= 1'b0;
            char_o    <= '0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
        end else begin
            load <= (state_q == ST_LOAD) && rx_en;
            if ((state_q == ST_LOAD) && rx_en) begin
                char_o    <= shreg_q >> shamt;
                frame_err <= ferr_q;
                par_err   <= par_en && (pbit_q != (xor_q ^ par_odd));
            end
        end
    end

    // R11: a disabled receiver sits in idle and never issues a transfer
    p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state_q == ST_IDLE));
    p_no_load_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !load);
    // R7: each completed frame yields a single transfer pulse
    p_load_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
    // R2: a start that reads high at its confirmation point is abandoned
    p_start_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && tick && cnt_zero && line && state_q == ST_START) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/rxa_hold_buf.sv
`timescale 1ns/1ps
module rxa_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] char_i,
    input  logic              frame_err_i,
    input  logic              par_err_i,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_rdy,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              err_parity
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_rdy      <= 1'b0;
            err_overrun <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
        end else if (load) begin
            rx_data     <= char_i;
            rx_rdy      <= 1'b1;
            err_overrun <= rx_rdy && !rd_ack;
            err_frame   <= frame_err_i;
            err_parity  <= par_err_i;
        end else if (rd_ack) begin
            rx_rdy <= 1'b0;
        end
    end

    p_rdy_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rx_rdy);
    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rx_data));
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !load) |=> !rx_rdy);
    p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rx_rdy && !rd_ack) |=> err_overrun);
    p_overrun_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !rx_rdy) |=> !err_overrun);

endmodule

// File: rtl/rxa_break_det.sv
`timescale 1ns/1ps
module rxa_break_det #(
    parameter int BRK_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic             rx_en,
    input  logic [BRK_W-1:0] limit,
    output logic             brk
);

    logic [BRK_W-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            brk       <= 1'b0;
        end else if (!rx_en || (tick && line)) begin
            low_cnt_q <= '0;
            brk       <= 1'b0;
        end else if (tick) begin
            if (low_cnt_q == limit) brk <= 1'b1;
            else                    low_cnt_q <= low_cnt_q + BRK_W'(1);
        end
    end

    p_brk_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && line) |=> !brk);
    p_brk_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !brk);

endmodule

// File: rtl/async_rx_dbuf.sv
`timescale 1ns/1ps
module async_rx_dbuf #(
    parameter int DATA_W      = 8,
    parameter int MID_FACTOR  = 16,
    parameter int HIGH_FACTOR = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              rx_en,
    input  logic              rxd,
    input  logic [1:0]        rate_sel,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop_two,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_rdy,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              err_parity,
    output logic              brk_det
);

    localparam int CNT_W     = $clog2(HIGH_FACTOR);
    localparam int LEN_W     = $clog2(DATA_W);
    localparam int MAX_FRAME = DATA_W + 4;
    localparam int BRK_W     = $clog2(2 * MAX_FRAME * HIGH_FACTOR + 1);

    logic              line;
    logic              is_x1;
    logic [CNT_W-1:0]  full_m1;
    logic [CNT_W-1:0]  half_m1;
    logic [BRK_W-1:0]  brk_factor;
    logic [LEN_W-1:0]  nbits_m1;
    logic [3:0]        frame_bits;
    logic [BRK_W-1:0]  brk_ticks;
    logic [BRK_W-1:0]  brk_limit;
    logic              load;
    logic [DATA_W-1:0] char_w;
    logic              ferr_w;
    logic              perr_w;

    // Rate decode: sample pulses per bit and half-bit point
    always_comb begin
        unique case (rate_sel)
            2'b00: begin
                is_x1      = 1'b1;
                full_m1    = '0;
                half_m1    = '0;
                brk_factor = BRK_W'(1);
            end
            2'b01: begin
                is_x1      = 1'b0;
                full_m1    = CNT_W'(MID_FACTOR - 1);
                half_m1    = CNT_W'(MID_FACTOR / 2 - 1);
                brk_factor = BRK_W'(MID_FACTOR);
            end
            default: begin
                is_x1      = 1'b0;
                full_m1    = CNT_W'(HIGH_FACTOR - 1);
                half_m1    = CNT_W'(HIGH_FACTOR / 2 - 1);
                brk_factor = BRK_W'(HIGH_FACTOR);
            end
        endcase
    end

    assign nbits_m1   = LEN_W'(char_len) + LEN_W'(4);
    assign frame_bits = 4'd6 + {2'b00, char_len} + {3'b000, par_en} + (stop_two ? 4'd2 : 4'd1);
    assign brk_ticks  = BRK_W'(frame_bits) * brk_factor;
    assign brk_limit  = (brk_ticks << 1) - BRK_W'(1);

    rxa_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd   (rxd),
        .line  (line)
    );

    rxa_frame_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (smp_en),
        .line      (line),
        .rx_en     (rx_en),
        .is_x1     (is_x1),
        .full_m1   (full_m1),
        .half_m1   (half_m1),
        .nbits_m1  (nbits_m1),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .stop_two  (stop_two),
        .load      (load),
        .char_o    (char_w),
        .frame_err (ferr_w),
        .par_err   (perr_w)
    );

    rxa_hold_buf #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .char_i      (char_w),
        .frame_err_i (ferr_w),
        .par_err_i   (perr_w),
        .rd_ack      (rd_ack),
        .rx_data     (rx_data),
        .rx_rdy      (rx_rdy),
        .err_overrun (err_overrun),
        .err_frame   (err_frame),
        .err_parity  (err_parity)
    );

    rxa_break_det #(.BRK_W(BRK_W)) u_brk (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (smp_en),
        .line  (line),
        .rx_en (rx_en),
        .limit (brk_limit),
        .brk   (brk_det)
    );

endmodule

// File: tb/async_rx_dbuf_tb_top.sv
`timescale 1ns/1ps
module async_rx_dbuf_tb_top;

    typedef struct packed {
        logic [1:0] rate;
        logic [1:0] len;
        logic       pen;
        logic       podd;
        logic       s2;
        logic [7:0] data;
        logic       bad_stop;
        logic       bad_par;
        logic [7:0] exp_data;
        logic       exp_fe;
        logic       exp_pe;
    } vec_t;

    // rate, len, pen, podd, s2, data, bad_stop, bad_par, exp_data, exp_fe, exp_pe
    localparam vec_t VECS [0:7] = '{
        '{2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
        '{2'b10, 2'b11, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
        '{2'b00, 2'b11, 1'b1, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0},
        '{2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
        '{2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 8'h55, 1'b0, 1'b1},
        '{2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 8'h2A, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b0},
        '{2'b11, 2'b11, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        '{2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 8'h3F, 1'b1, 1'b0, 8'h3F, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en = 1'b0;
    logic       rx_en = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] rate_sel = 2'b01;
    logic [1:0] char_len = 2'b11;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop_two = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_rdy;
    logic       err_overrun;
    logic       err_frame;
    logic       err_parity;
    logic       brk_det;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    async_rx_dbuf dut_i (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .rx_en(rx_en), .rxd(rxd),
        .rate_sel(rate_sel), .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .stop_two(stop_two), .rd_ack(rd_ack), .rx_data(rx_data), .rx_rdy(rx_rdy),
        .err_overrun(err_overrun), .err_frame(err_frame), .err_parity(err_parity),
        .brk_det(brk_det)
    );

    // One sample pulse every fourth clock
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            smp_en = 1'b1;
            @(negedge clk);
            smp_en = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!smp_en);
    endtask

    function automatic int factor_of(input logic [1:0] r);
        if (r == 2'b00) return 1;
        if (r == 2'b01) return 16;
        return 64;
    endfunction

    task automatic build_frame(input logic [7:0] d, input int n, input logic pen, input logic podd,
                               input logic s2, input logic bad_stop, input logic bad_par,
                               output logic [15:0] b, output int cnt);
        logic p;
        b = '1;
        cnt = 0;
        b[cnt] = 1'b0; cnt++;
        p = podd;
        for (int i = 0; i < n; i++) begin
            b[cnt] = d[i]; cnt++;
            p ^= d[i];
        end
        if (pen) begin
            b[cnt] = bad_par ? ~p : p; cnt++;
        end
        b[cnt] = ~bad_stop; cnt++;
        if (s2) begin
            b[cnt] = 1'b1; cnt++;
        end
    endtask

    // Must be entered right after a sample-pulse edge
    task automatic send_seg(input logic [15:0] b, input int lo, input int hi, input int f);
        for (int i = lo; i < hi; i++) begin
            @(negedge clk) rxd = b[i];
            repeat (f) wait_tick();
        end
    endtask

    task automatic idle_ticks(input int n);
        @(negedge clk) rxd = 1'b1;
        repeat (n) wait_tick();
    endtask

    task automatic set_cfg(input logic [1:0] r, input logic [1:0] l, input logic pe,
                           input logic po, input logic s2);
        @(negedge clk);
        rate_sel = r; char_len = l; par_en = pe; par_odd = po; stop_two = s2;
    endtask

    task automatic host_read();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    task automatic send_char(input logic [7:0] d);
        logic [15:0] b;
        int cnt;
        build_frame(d, 5 + int'(char_len), par_en, par_odd, stop_two, 1'b0, 1'b0, b, cnt);
        idle_ticks(4);
        send_seg(b, 0, cnt, factor_of(rate_sel));
        idle_ticks(3);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] bits;
        int cnt;
        logic [7:0] held;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "rx_rdy", rx_rdy, 0);
        chk("R1", "rx_data", rx_data, 0);
        chk("R1", "err_overrun", err_overrun, 0);
        chk("R1", "err_frame", err_frame, 0);
        chk("R1", "err_parity", err_parity, 0);
        chk("R1", "brk_det", brk_det, 0);

        // Vector table: R3 R4 R5 R6 R7 R8 across rates, lengths, parity, stops
        foreach (VECS[i]) begin
            set_cfg(VECS[i].rate, VECS[i].len, VECS[i].pen, VECS[i].podd, VECS[i].s2);
            build_frame(VECS[i].data, 5 + int'(VECS[i].len), VECS[i].pen, VECS[i].podd,
                        VECS[i].s2, VECS[i].bad_stop, VECS[i].bad_par, bits, cnt);
            idle_ticks(4);
            send_seg(bits, 0, cnt, factor_of(VECS[i].rate));
            idle_ticks(3);
            @(negedge clk);
            chk("R7", $sformatf("vec%0d rx_rdy", i), rx_rdy, 1);
            chk("R3 R4", $sformatf("vec%0d data", i), rx_data, VECS[i].exp_data);
            chk("R6", $sformatf("vec%0d err_frame", i), err_frame, VECS[i].exp_fe);
            chk("R5", $sformatf("vec%0d err_parity", i), err_parity, VECS[i].exp_pe);
            chk("R9", $sformatf("vec%0d err_overrun", i), err_overrun, 0);
            host_read();
            @(negedge clk);
            chk("R8", $sformatf("vec%0d rx_rdy after read", i), rx_rdy, 0);
            chk("R8", $sformatf("vec%0d data after read", i), rx_data, VECS[i].exp_data);
        end

        // R2: short low glitch at 16x is rejected at the half-bit check
        set_cfg(2'b01, 2'b11, 1'b0, 1'b0, 1'b0);
        held = rx_data;
        idle_ticks(4);
        @(negedge clk) rxd = 1'b0;
        repeat (5) wait_tick();
        idle_ticks(40);
        @(negedge clk);
        chk("R2", "rx_rdy after glitch", rx_rdy, 0);
        chk("R2", "data after glitch", rx_data, held);

        // R7, R9: data held during the next frame; overrun on unread character
        send_char(8'h11);
        @(negedge clk);
        chk("R7", "first char", rx_data, 8'h11);
        build_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, bits, cnt);
        idle_ticks(4);
        send_seg(bits, 0, 4, 16);
        @(negedge clk);
        chk("R7", "data stable mid-frame", rx_data, 8'h11);
        wait_tick();
        send_seg(bits, 4, cnt, 16);
        idle_ticks(3);
        @(negedge clk);
        chk("R9", "overrun data", rx_data, 8'h22);
        chk("R9", "overrun flag set", err_overrun, 1);
        chk("R9", "rx_rdy still set", rx_rdy, 1);
        host_read();
        send_char(8'h33);
        @(negedge clk);
        chk("R9", "overrun flag clear", err_overrun, 0);
        chk("R9", "data after clean load", rx_data, 8'h33);
        host_read();

        // R11: disabled receiver ignores the line
        @(negedge clk) rx_en = 1'b0;
        send_char(8'h5A);
        @(negedge clk);
        chk("R11", "rx_rdy while disabled", rx_rdy, 0);
        chk("R11", "data while disabled", rx_data, 8'h33);
        @(negedge clk) rxd = 1'b0;
        repeat (400) wait_tick();
        @(negedge clk);
        chk("R11", "brk while disabled", brk_det, 0);
        chk("R11", "rx_rdy after long low", rx_rdy, 0);
        idle_ticks(4);
        @(negedge clk) rx_en = 1'b1;
        idle_ticks(4);

        // R10: 16x, 8 data, no parity, 1 stop -> 10 bits, limit 320 ticks
        @(negedge clk) rxd = 1'b0;
        repeat (300) wait_tick();
        @(negedge clk);
        chk("R10", "brk before limit 16x", brk_det, 0);
        repeat (25) wait_tick();
        @(negedge clk);
        chk("R10", "brk after limit 16x", brk_det, 1);
        chk("R6", "break char framing", err_frame, 1);
        chk("R6", "break char data", rx_data, 8'h00);
        idle_ticks(2);
        @(negedge clk);
        chk("R10", "brk released", brk_det, 0);
        host_read();

        // R10: 1x, 8 data, parity, 2 stops -> 12 bits, limit 24 ticks
        set_cfg(2'b00, 2'b11, 1'b1, 1'b0, 1'b1);
        idle_ticks(4);
        @(negedge clk) rxd = 1'b0;
        repeat (20) wait_tick();
        @(negedge clk);
        chk("R10", "brk before limit 1x", brk_det, 0);
        repeat (6) wait_tick();
        @(negedge clk);
        chk("R10", "brk after limit 1x", brk_det, 1);
        idle_ticks(2);
        @(negedge clk);
        chk("R10", "brk released 1x", brk_det, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule